// File: doc/BRIEF.md
# Sequential Unsigned Divider with Defined Zero-Divisor Result

This block divides two unsigned integers over a fixed number of clocks and hands back the quotient and the remainder. It works on 16-bit register halves. The caller supplies a dividend made of a low and a high word, and a divisor made of a low and a high word. The quotient comes back in the dividend's place and the remainder in the divisor's place, so the surrounding register file can write all four words back. The register file itself is outside this block.

There are two modes, chosen by `mode_wide` when the operation is accepted. In the narrow mode only the low words take part: a 16-bit dividend is divided by a 16-bit divisor. The two high words are returned exactly as they were captured, so a full write-back leaves them unchanged. In the wide mode the high and low words together form a 32-bit dividend and a 32-bit divisor. Division by zero is not an error. It gives a quotient of all ones and a remainder equal to the dividend. The latency depends only on the mode.

Control is a three-state machine.
- `ST_IDLE` waits for `op_start`. On an accepted start it moves to `ST_CALC` and captures the operands.
- `ST_CALC` runs restoring shift-subtract steps, two quotient bits per clock, counting down a step counter. It stays in `ST_CALC` while the counter is non-zero and moves to `ST_DONE` when the counter reaches zero.
- `ST_DONE` raises `done_o` for one cycle and always returns to `ST_IDLE`.

Top module: `udiv_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy_o` and `done_o` are 0 and all four result words are 0 until the first accepted start.
- R2: Narrow mode (`mode_wide` = 0):
  - the dividend is `dvd_lo_i` and the divisor is `dvs_lo_i`;
  - `quo_lo_o` is the quotient and `rem_lo_o` is the remainder;
  - `quo_hi_o` and `rem_hi_o` return the `dvd_hi_i` and `dvs_hi_i` values captured at acceptance.
- R3: Wide mode (`mode_wide` = 1):
  - the dividend is {`dvd_hi_i`,`dvd_lo_i`} (high word first) and the divisor is {`dvs_hi_i`,`dvs_lo_i`};
  - the quotient is {`quo_hi_o`,`quo_lo_o`} and the remainder is {`rem_hi_o`,`rem_lo_o`}.
- R4: With a zero divisor (narrow: `dvs_lo_i` = 0; wide: both divisor words 0):
  - the quotient is all ones (0xFFFF narrow, 0xFFFFFFFF wide);
  - the remainder equals the dividend.
- R5: A start is accepted on a rising edge where `op_start` = 1 and `busy_o` = 0. After that edge `busy_o` is high for exactly 9 cycles (narrow) or 17 cycles (wide). `done_o` is high in the last of those cycles only, and busy falls right after it.
- R6: `op_start` while `busy_o` = 1 is ignored. This includes the `done_o` cycle. Such a start neither restarts nor lengthens the running operation and does not change its results.
- R7: Operand words and `mode_wide` are sampled only at the accepting edge. Changes to them during the operation do not affect the results.
- R8: Results are valid in the `done_o` cycle. They then hold unchanged while idle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_start | input | 1 | Request a division (accepted only when idle) |
| mode_wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| dvd_lo_i | input | 16 | Dividend low word |
| dvd_hi_i | input | 16 | Dividend high word (wide mode) |
| dvs_lo_i | input | 16 | Divisor low word |
| dvs_hi_i | input | 16 | Divisor high word (wide mode) |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse, results valid |
| quo_lo_o | output | 16 | Quotient low word |
| quo_hi_o | output | 16 | Quotient high word, or captured dividend high word in narrow mode |
| rem_lo_o | output | 16 | Remainder low word |
| rem_hi_o | output | 16 | Remainder high word, or captured divisor high word in narrow mode |

## Verification
The divider is tried in both modes with a range of fixed operand pairs:
- a dividend smaller than the divisor, which should give a zero quotient and the remainder equal to the dividend;
- a divisor of one, which should give the full dividend as quotient;
- equal operands;
- all-ones operands;
- a zero dividend;
- a divisor with only its high word set, which separates true 32-bit handling from low-word-only handling.

Zero divisors in both modes show whether the all-ones quotient rule applies at the right width. Random operands, some with small divisors to exercise long quotients, cover general arithmetic. Other runs scramble the operand inputs and pulse start while busy, which separates a design that samples once from one that re-captures or restarts. Idle gaps with changing inputs show whether the results hold.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_DONE = 2'd2
    } udiv_state_e;

    // Clocks spent in ST_CALC for an operand of the given bit count
    function automatic int calc_clocks(input int bits, input int steps_per_clk);
        return bits / steps_per_clk;
    endfunction

endpackage

// File: rtl/udiv_step.sv
// One restoring shift-subtract step: brings in the next dividend bit,
// tries the subtraction and keeps it when no borrow results.
module udiv_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] sh_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] sh_o
);

    logic [W:0] partial;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        partial = {rem_i, sh_i[W-1]};
        trial   = partial - {1'b0, dvs_i};
        fits    = ~trial[W];
        rem_o   = fits ? trial[W-1:0] : partial[W-1:0];
        sh_o    = {sh_i[W-2:0], fits};
    end

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int STEPS_PER_CLK = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic mode_wide,
    output logic load,
    output logic step_en,
    output logic busy,
    output logic done
);

    localparam int NARROW_CLKS = calc_clocks(DATA_W, STEPS_PER_CLK);
    localparam int WIDE_CLKS   = calc_clocks(2 * DATA_W, STEPS_PER_CLK);
    localparam int CNT_W       = $clog2(WIDE_CLKS + 1);

    udiv_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and step counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (op_start) begin
                    state_d = ST_CALC;
                    cnt_d   = mode_wide ? CNT_W'(WIDE_CLKS - 1)
                                        : CNT_W'(NARROW_CLKS - 1);
                end
            end
            ST_CALC: begin
                if (cnt_zero) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        load    = 1'b0;
        step_en = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: load = op_start;
            ST_CALC: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
    parameter int DATA_W        = 16,
    parameter int STEPS_PER_CLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step_en,
    input  logic              mode_wide,
    input  logic [DATA_W-1:0] dvd_lo_i,
    input  logic [DATA_W-1:0] dvd_hi_i,
    input  logic [DATA_W-1:0] dvs_lo_i,
    input  logic [DATA_W-1:0] dvs_hi_i,
    output logic [DATA_W-1:0] quo_lo_o,
    output logic [DATA_W-1:0] quo_hi_o,
    output logic [DATA_W-1:0] rem_lo_o,
    output logic [DATA_W-1:0] rem_hi_o
);

    localparam int W = 2 * DATA_W;

    logic [W-1:0]      sh_q;     // dividend shifting out, quotient shifting in
    logic [W-1:0]      rem_q;    // partial remainder
    logic [W-1:0]      dvs_q;    // divisor
    logic              wide_q;
    logic [DATA_W-1:0] dvd_hi_keep;
    logic [DATA_W-1:0] dvs_hi_keep;

    logic [STEPS_PER_CLK:0][W-1:0] rem_c;
    logic [STEPS_PER_CLK:0][W-1:0] sh_c;

    assign rem_c[0] = rem_q;
    assign sh_c[0]  = sh_q;

    // Unrolled steps per clock
    for (genvar g = 0; g < STEPS_PER_CLK; g++) begin : g_step
        udiv_step #(.W(W)) u_step (
            .rem_i (rem_c[g]),
            .sh_i  (sh_c[g]),
            .dvs_i (dvs_q),
            .rem_o (rem_c[g+1]),
            .sh_o  (sh_c[g+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q        <= '0;
            rem_q       <= '0;
            dvs_q       <= '0;
            wide_q      <= 1'b0;
            dvd_hi_keep <= '0;
            dvs_hi_keep <= '0;
        end else if (load) begin
            // Narrow dividend sits in the top half so the MSB-first walk
            // covers exactly DATA_W bits.
            sh_q        <= mode_wide ? {dvd_hi_i, dvd_lo_i}
                                     : {dvd_lo_i, {DATA_W{1'b0}}};
            rem_q       <= '0;
            dvs_q       <= mode_wide ? {dvs_hi_i, dvs_lo_i}
                                     : {{DATA_W{1'b0}}, dvs_lo_i};
            wide_q      <= mode_wide;
            dvd_hi_keep <= dvd_hi_i;
            dvs_hi_keep <= dvs_hi_i;
        end else if (step_en) begin
            sh_q  <= sh_c[STEPS_PER_CLK];
            rem_q <= rem_c[STEPS_PER_CLK];
        end
    end

    always_comb begin
        quo_lo_o = sh_q[DATA_W-1:0];
        rem_lo_o = rem_q[DATA_W-1:0];
        quo_hi_o = wide_q ? sh_q[W-1:DATA_W]  : dvd_hi_keep;
        rem_hi_o = wide_q ? rem_q[W-1:DATA_W] : dvs_hi_keep;
    end

endmodule

// File: rtl/udiv_seq.sv
module udiv_seq #(
    parameter int DATA_W        = 16,
    parameter int STEPS_PER_CLK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic              mode_wide,
    input  logic [DATA_W-1:0] dvd_lo_i,
    input  logic [DATA_W-1:0] dvd_hi_i,
    input  logic [DATA_W-1:0] dvs_lo_i,
    input  logic [DATA_W-1:0] dvs_hi_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quo_lo_o,
    output logic [DATA_W-1:0] quo_hi_o,
    output logic [DATA_W-1:0] rem_lo_o,
    output logic [DATA_W-1:0] rem_hi_o
);

    logic load;
    logic step_en;

    udiv_ctrl #(
        .DATA_W        (DATA_W),
        .STEPS_PER_CLK (STEPS_PER_CLK)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .mode_wide (mode_wide),
        .load      (load),
        .step_en   (step_en),
        .busy      (busy_o),
        .done      (done_o)
    );

    udiv_datapath #(
        .DATA_W        (DATA_W),
        .STEPS_PER_CLK (STEPS_PER_CLK)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step_en   (step_en),
        .mode_wide (mode_wide),
        .dvd_lo_i  (dvd_lo_i),
        .dvd_hi_i  (dvd_hi_i),
        .dvs_lo_i  (dvs_lo_i),
        .dvs_hi_i  (dvs_hi_i),
        .quo_lo_o  (quo_lo_o),
        .quo_hi_o  (quo_hi_o),
        .rem_lo_o  (rem_lo_o),
        .rem_hi_o  (rem_hi_o)
    );

endmodule

// File: rtl/udiv_seq_chk.sv
module udiv_seq_chk #(
    parameter int DATA_W        = 16,
    parameter int STEPS_PER_CLK = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_start,
    input logic              mode_wide,
    input logic [DATA_W-1:0] dvd_lo_i,
    input logic [DATA_W-1:0] dvd_hi_i,
    input logic [DATA_W-1:0] dvs_lo_i,
    input logic [DATA_W-1:0] dvs_hi_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] quo_lo_o,
    input logic [DATA_W-1:0] quo_hi_o,
    input logic [DATA_W-1:0] rem_lo_o,
    input logic [DATA_W-1:0] rem_hi_o
);

    localparam int W        = 2 * DATA_W;
    localparam int LAT_NAR  = DATA_W / STEPS_PER_CLK + 1;
    localparam int LAT_WIDE = W / STEPS_PER_CLK + 1;
    localparam int CYC_W    = $clog2(LAT_WIDE + 2);

    logic              accept;
    logic              wide_l;
    logic              zero_l;
    logic [W-1:0]      dvd_l;
    logic [W-1:0]      dvs_l;
    logic [DATA_W-1:0] dvd_hi_l;
    logic [DATA_W-1:0] dvs_hi_l;
    logic [CYC_W-1:0]  cyc;

    assign accept = op_start && !busy_o;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_l   <= 1'b0;
            zero_l   <= 1'b0;
            dvd_l    <= '0;
            dvs_l    <= '0;
            dvd_hi_l <= '0;
            dvs_hi_l <= '0;
            cyc      <= '0;
        end else if (accept) begin
            wide_l   <= mode_wide;
            zero_l   <= mode_wide ? ({dvs_hi_i, dvs_lo_i} == '0) : (dvs_lo_i == '0);
            dvd_l    <= mode_wide ? {dvd_hi_i, dvd_lo_i} : {{DATA_W{1'b0}}, dvd_lo_i};
            dvs_l    <= mode_wide ? {dvs_hi_i, dvs_lo_i} : {{DATA_W{1'b0}}, dvs_lo_i};
            dvd_hi_l <= dvd_hi_i;
            dvs_hi_l <= dvs_hi_i;
            cyc      <= CYC_W'(1);
        end else if (busy_o) begin
            cyc <= cyc + CYC_W'(1);
        end
    end

    // R5: done arrives after the fixed per-mode latency
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc == (wide_l ? CYC_W'(LAT_WIDE) : CYC_W'(LAT_NAR))));

    // R5: done is a single pulse that ends the busy period
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

    assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    // R6: busy only starts from a start request
    assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(op_start));

    // R4: zero divisor rule
    assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && zero_l) |->
            (wide_l ? (({quo_hi_o, quo_lo_o} == {W{1'b1}}) && ({rem_hi_o, rem_lo_o} == dvd_l))
                    : ((quo_lo_o == {DATA_W{1'b1}}) && (rem_lo_o == dvd_l[DATA_W-1:0]))));

    // R2 and R3: remainder is below a non-zero divisor
    assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !zero_l) |->
            (wide_l ? ({rem_hi_o, rem_lo_o} < dvs_l)
                    : ({{DATA_W{1'b0}}, rem_lo_o} < dvs_l)));

    // R2: narrow mode returns captured high words unchanged
    assert_high_passthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wide_l) |-> ((quo_hi_o == dvd_hi_l) && (rem_hi_o == dvs_hi_l)));

    // R8: results hold while idle without a start
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !op_start) |=> $stable({quo_hi_o, quo_lo_o, rem_hi_o, rem_lo_o}));

endmodule

bind udiv_seq udiv_seq_chk #(
    .DATA_W        (DATA_W),
    .STEPS_PER_CLK (STEPS_PER_CLK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_start  (op_start),
    .mode_wide (mode_wide),
    .dvd_lo_i  (dvd_lo_i),
    .dvd_hi_i  (dvd_hi_i),
    .dvs_lo_i  (dvs_lo_i),
    .dvs_hi_i  (dvs_hi_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .quo_lo_o  (quo_lo_o),
    .quo_hi_o  (quo_hi_o),
    .rem_lo_o  (rem_lo_o),
    .rem_hi_o  (rem_hi_o)
);

// File: tb/udiv_seq_bench.sv
`timescale 1ns/1ps
module udiv_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_start = 1'b0;
    logic        mode_wide = 1'b0;
    logic [15:0] dvd_lo_i = '0, dvd_hi_i = '0, dvs_lo_i = '0, dvs_hi_i = '0;
    logic        busy_o, done_o;
    logic [15:0] quo_lo_o, quo_hi_o, rem_lo_o, rem_hi_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    string cur_req = "R1";
    bit finished = 0;

    // Reference model state
    int          m_cnt = 0;
    logic [15:0] e_ql = '0, e_qh = '0, e_rl = '0, e_rh = '0;

    always #4 clk = ~clk;   // 125 MHz

    udiv_seq u_udiv_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_start  (op_start),
        .mode_wide (mode_wide),
        .dvd_lo_i  (dvd_lo_i),
        .dvd_hi_i  (dvd_hi_i),
        .dvs_lo_i  (dvs_lo_i),
        .dvs_hi_i  (dvs_hi_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .quo_lo_o  (quo_lo_o),
        .quo_hi_o  (quo_hi_o),
        .rem_lo_o  (rem_lo_o),
        .rem_hi_o  (rem_hi_o)
    );

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0;
            e_ql = '0; e_qh = '0; e_rl = '0; e_rh = '0;
        end else if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
        end else if (op_start) begin
            if (mode_wide) begin
                logic [31:0] dd, ds, q, r;
                dd = {dvd_hi_i, dvd_lo_i};
                ds = {dvs_hi_i, dvs_lo_i};
                if (ds == 0) begin q = 32'hFFFF_FFFF; r = dd; end
                else begin q = dd / ds; r = dd % ds; end
                e_ql = q[15:0]; e_qh = q[31:16];
                e_rl = r[15:0]; e_rh = r[31:16];
                m_cnt = 17;
            end else begin
                logic [15:0] dd, ds, q, r;
                dd = dvd_lo_i;
                ds = dvs_lo_i;
                if (ds == 0) begin q = 16'hFFFF; r = dd; end
                else begin q = dd / ds; r = dd % ds; end
                e_ql = q; e_rl = r;
                e_qh = dvd_hi_i; e_rh = dvs_hi_i;
                m_cnt = 9;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d",
                     tag, what, act, exp, n_cyc);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!finished) begin
            string ctl_tag;
            ctl_tag = (cur_req == "R1") ? "R1" : "R5";
            chk(ctl_tag, "busy", {31'b0, busy_o}, {31'b0, (m_cnt > 0)});
            chk(ctl_tag, "done", {31'b0, done_o}, {31'b0, (m_cnt == 1)});
            if (m_cnt == 0 || m_cnt == 1) begin
                chk(cur_req, "quo_lo", {16'b0, quo_lo_o}, {16'b0, e_ql});
                chk(cur_req, "quo_hi", {16'b0, quo_hi_o}, {16'b0, e_qh});
                chk(cur_req, "rem_lo", {16'b0, rem_lo_o}, {16'b0, e_rl});
                chk(cur_req, "rem_hi", {16'b0, rem_hi_o}, {16'b0, e_rh});
            end
        end
    end

    task automatic finish_run();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog expired at cycle %0d", n_cyc);
            finish_run();
        end
    end

    // disturb: 0 none, 1 scramble operands and pulse start while busy
    task automatic do_op(input string tag, input logic wide,
                         input logic [15:0] dl, input logic [15:0] dh,
                         input logic [15:0] sl, input logic [15:0] sh,
                         input int disturb, input int idle_gap);
        @(negedge clk);
        cur_req   = tag;
        mode_wide = wide;
        dvd_lo_i = dl; dvd_hi_i = dh; dvs_lo_i = sl; dvs_hi_i = sh;
        op_start = 1'b1;
        @(negedge clk);
        op_start = 1'b0;
        while (m_cnt != 0) begin
            if (disturb != 0) begin
                dvd_lo_i  = 16'($urandom);
                dvd_hi_i  = 16'($urandom);
                dvs_lo_i  = 16'($urandom);
                dvs_hi_i  = 16'($urandom);
                mode_wide = 1'($urandom);
                op_start  = 1'($urandom);
            end
            @(negedge clk);
        end
        op_start = 1'b0;
        for (int i = 0; i < idle_gap; i++) begin
            dvd_lo_i = 16'($urandom);
            dvs_lo_i = 16'($urandom);
            mode_wide = 1'($urandom);
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: narrow mode patterns
        do_op("R2", 1'b0, 16'd100,  16'h1111, 16'd7,     16'h2222, 0, 0);
        do_op("R2", 1'b0, 16'hFFFF, 16'h0,    16'd1,     16'hABCD, 0, 0);
        do_op("R2", 1'b0, 16'd5,    16'h5A5A, 16'd9,     16'hA5A5, 0, 0);
        do_op("R2", 1'b0, 16'hFFFF, 16'h1234, 16'hFFFF,  16'h0,    0, 0);
        do_op("R2", 1'b0, 16'd0,    16'h0,    16'd5,     16'h0,    0, 1);
        // R3: wide mode patterns
        do_op("R3", 1'b1, 16'hBEEF, 16'hDEAD, 16'h1234,  16'h0,    0, 0);
        do_op("R3", 1'b1, 16'hFFFF, 16'hFFFF, 16'd1,     16'h0,    0, 0);
        do_op("R3", 1'b1, 16'h0,    16'h1,    16'h0,     16'h1,    0, 0);
        do_op("R3", 1'b1, 16'h5678, 16'h1234, 16'h4321,  16'h8765, 0, 0);
        do_op("R3", 1'b1, 16'h0001, 16'h8000, 16'h0,     16'h0003, 0, 2);
        // R4: zero divisors in both modes
        do_op("R4", 1'b0, 16'h1234, 16'h9999, 16'h0,     16'h7777, 0, 0);
        do_op("R4", 1'b1, 16'h5678, 16'h1234, 16'h0,     16'h0,    0, 0);
        do_op("R4", 1'b1, 16'hFFFF, 16'hFFFF, 16'h0,     16'h0,    0, 0);
        do_op("R4", 1'b0, 16'h0,    16'h0,    16'h0,     16'h0,    0, 0);
        // R5: latency with back-to-back starts
        for (int i = 0; i < 10; i++)
            do_op("R5", 1'(i % 2), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 0, 0);
        // R6 / R7: start pulses and operand churn while busy
        for (int i = 0; i < 20; i++)
            do_op((i % 2) ? "R7" : "R6", 1'(i / 2 % 2), 16'($urandom), 16'($urandom),
                  16'($urandom % 300), 16'((i % 4 == 3) ? $urandom % 4 : 0), 1, 0);
        // R8: results hold across idle gaps with changing inputs
        do_op("R8", 1'b1, 16'h4321, 16'h0FED, 16'h0077, 16'h0, 0, 8);
        do_op("R8", 1'b0, 16'h9876, 16'h0A0A, 16'h0033, 16'hB0B0, 0, 8);
        // Random sweep in both modes
        for (int i = 0; i < 120; i++)
            do_op((i % 2) ? "R3" : "R2", 1'(i % 2), 16'($urandom), 16'($urandom),
                  (i % 3 == 0) ? 16'($urandom % 256) : 16'($urandom),
                  (i % 5 == 0) ? 16'h0 : 16'($urandom), 0, i % 3);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule